// File: doc/BRIEF.md
# Two-Step Ramp Conversion Sequencer

This block runs one column of a two-step single-slope analog-to-digital conversion and builds the digital result. A start strobe launches a coarse ramp phase. A counter advances one step per clock and is captured when the external comparator output rises. The coarse ramp voltage is then held and a fine ramp phase runs the same way, but over twice the nominal fine range. The captured coarse and fine codes are merged into one 14-bit word.

The fine code is one bit wider than the nominal 7 fine bits. Its ramp covers two coarse steps, so a coarse decision that lands one step off is corrected when the codes are merged. The comparator reaches the block through a two-flop synchronizer, and the capture logic compensates for the synchronizer latency. A full conversion fits inside a budget of 500 clocks, which is 12.5 µs at 40 MHz.

Top module: `twostep_ramp_seq`

## Requirements
- R1: After reset, `coarse_ramp_o`, `fine_ramp_o`, `hold_o` and `valid_o` are low and `code_o` is 0.
- R2: A `start_i` pulse seen while idle starts the coarse phase. The k-th clock (counting from 0) with `coarse_ramp_o` high applies coarse step k. There are at most 128 such clocks, steps 0 to 127.
- R3: The coarse code is the first coarse step k for which `cmp_i` was high during that step's clock, after the two-flop synchronizer delay is removed. If `cmp_i` is never high, the coarse code is 127.
- R4: After a coarse trip at step k, `coarse_ramp_o` stays high for exactly min(k+3, 128) clocks in total. `hold_o` is high on every clock of the fine phase. The comparator history is cleared when a phase begins.
- R5: The fine code is 8 bits wide. It is the first fine step k (0 to 255) for which `cmp_i` was high, with the k-th clock of `fine_ramp_o` applying step k. If `cmp_i` is never high, the fine code is 255.
- R6: `code_o` = coarse×128 + fine − 64, clamped to the range 0 to 16383.
- R7: `valid_o` is high for exactly one clock per conversion. `code_o` changes only together with `valid_o` and then holds its value.
- R8: `start_i` has no effect while a conversion is in progress. The result of that conversion is unchanged, and no second conversion follows it.
- R9: `valid_o` rises no later than 500 clocks after the `start_i` pulse.
- R10: `coarse_ramp_o` and `fine_ramp_o` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, acted on only when idle |
| cmp_i | input | 1 | Asynchronous comparator output, high once the ramp passes the pixel level |
| coarse_ramp_o | output | 1 | Coarse ramp advances one step per clock while high |
| fine_ramp_o | output | 1 | Fine ramp advances one step per clock while high |
| hold_o | output | 1 | Keeps the coarse ramp voltage on the hold capacitor |
| code_o | output | 14 | Corrected merged conversion code |
| valid_o | output | 1 | One-clock strobe marking a new `code_o` |

## Verification
The assertions assume a single clean start pulse and a comparator that, once it rises within a phase, stays high until that phase ends. The capture logic acts only on the first synchronized rising level. The bench models the comparator as a step function of the ramp step index that it counts from the ramp controls. It drives the comparator low whenever neither ramp is active, so each phase begins from a clean comparator. The bench sweeps every coarse trip point, spreads fine trip points over the whole 0 to 255 range including the no-trip case, and issues extra start pulses only in the middle of a conversion.

// File: rtl/twostep_ramp_pkg.sv
package twostep_ramp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_COARSE = 2'd1,
      ST_FINE   = 2'd2,
      ST_DONE   = 2'd3
   } tsr_state_e;
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      initial $error("tsr_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] s_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n || clr) s_q <= '0;
         else               s_q <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk) begin
         if (!rst_n || clr) s_q <= '0;
         else               s_q <= {s_q[STAGES-2:0], d};
      end
   end

   assign q = s_q[STAGES-1];

   AST_SYNC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !q); // R4
endmodule

// File: rtl/tsr_merge.sv
module tsr_merge #(
   parameter int CRS_W   = 7,
   parameter int FIN_W   = 7,
   parameter int OVERLAP = 64,
   localparam int FCODE_W = FIN_W + 1,
   localparam int OUT_W   = CRS_W + FIN_W
) (
   input  logic [CRS_W-1:0]   crs,
   input  logic [FCODE_W-1:0] fin,
   output logic [OUT_W-1:0]   code
);
   localparam int SUM_W = OUT_W + 2;
   localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << OUT_W) - 1);

   if (OVERLAP < 0 || OVERLAP >= (1 << FCODE_W)) begin : g_bad_ovl
      initial $error("tsr_merge: OVERLAP out of range");
   end

   logic signed [SUM_W-1:0] sum;

   always_comb begin
      sum = $signed({2'b00, crs, {FIN_W{1'b0}}})
          + $signed({{(SUM_W-FCODE_W){1'b0}}, fin});
   end

   if (OVERLAP == 0) begin : g_no_overlap
      always_comb code = (sum > MAXV) ? OUT_W'(MAXV) : sum[OUT_W-1:0];
   end else begin : g_overlap
      logic signed [SUM_W-1:0] adj;
      always_comb begin
         adj = sum - SUM_W'(OVERLAP);
         if (adj < 0)         code = '0;
         else if (adj > MAXV) code = OUT_W'(MAXV);
         else                 code = adj[OUT_W-1:0];
      end
   end
endmodule

// File: rtl/twostep_ramp_seq.sv
module twostep_ramp_seq
   import twostep_ramp_pkg::*;
#(
   parameter int CRS_W       = 7,
   parameter int FIN_W       = 7,
   parameter int OVERLAP     = 64,
   parameter int SYNC_STAGES = 2,
   parameter int MAX_CYC     = 500
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        cmp_i,
   output logic        coarse_ramp_o,
   output logic        fine_ramp_o,
   output logic        hold_o,
   output logic [13:0] code_o,
   output logic        valid_o
);
   localparam int FCODE_W  = FIN_W + 1;
   localparam int OUT_W    = CRS_W + FIN_W;
   localparam int C_STEPS  = 1 << CRS_W;
   localparam int F_STEPS  = 1 << FCODE_W;
   localparam int CNT_W    = $clog2(F_STEPS + SYNC_STAGES + 1);
   localparam int WORST    = C_STEPS + F_STEPS + 2 * SYNC_STAGES + 3;
   localparam int LAT_W    = $clog2(MAX_CYC + 2);
   localparam logic [CNT_W-1:0] C_END = CNT_W'(C_STEPS - 1 + SYNC_STAGES);
   localparam logic [CNT_W-1:0] F_END = CNT_W'(F_STEPS - 1 + SYNC_STAGES);

   if (OUT_W != 14) begin : g_bad_width
      initial $error("twostep_ramp_seq: CRS_W + FIN_W must equal 14");
   end
   if (WORST > MAX_CYC) begin : g_bad_budget
      initial $error("twostep_ramp_seq: worst case exceeds cycle budget");
   end

   tsr_state_e          state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [CRS_W-1:0]    crs_q;
   logic [FCODE_W-1:0]  fin_q;
   logic [OUT_W-1:0]    code_q;
   logic [OUT_W-1:0]    merged;
   logic                valid_q;
   logic                trip;
   logic                phase_end;
   logic                sync_clr;
   logic [CNT_W-1:0]    cnt_comp;

   always_comb begin
      cnt_comp  = cnt_q - CNT_W'(SYNC_STAGES);
      phase_end = ((state_q == ST_COARSE) && (trip || cnt_q == C_END)) ||
                  ((state_q == ST_FINE)   && (trip || cnt_q == F_END));
      sync_clr  = (state_q == ST_IDLE) || (state_q == ST_DONE) || phase_end;
   end

   tsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sync_clr),
      .d     (cmp_i),
      .q     (trip)
   );

   tsr_merge #(.CRS_W(CRS_W), .FIN_W(FIN_W), .OVERLAP(OVERLAP)) u_merge (
      .crs  (crs_q),
      .fin  (fin_q),
      .code (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         crs_q   <= '0;
         fin_q   <= '0;
         code_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (start_i) state_q <= ST_COARSE;
            end
            ST_COARSE: begin
               if (phase_end) begin
                  crs_q   <= trip ? CRS_W'(cnt_comp) : {CRS_W{1'b1}};
                  cnt_q   <= '0;
                  state_q <= ST_FINE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_FINE: begin
               if (phase_end) begin
                  fin_q   <= trip ? FCODE_W'(cnt_comp) : {FCODE_W{1'b1}};
                  cnt_q   <= '0;
                  state_q <= ST_DONE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: begin
               code_q  <= merged;
               valid_q <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign coarse_ramp_o = (state_q == ST_COARSE) && (cnt_q < CNT_W'(C_STEPS));
   assign fine_ramp_o   = (state_q == ST_FINE)   && (cnt_q < CNT_W'(F_STEPS));
   assign hold_o        = (state_q == ST_FINE)   || (state_q == ST_DONE);
   assign code_o        = code_q;
   assign valid_o       = valid_q;

   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk) begin
      if (!rst_n || state_q == ST_IDLE) lat_q <= '0;
      else if (lat_q != {LAT_W{1'b1}})  lat_q <= lat_q + 1'b1;
   end

   AST_ONE_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({coarse_ramp_o, fine_ramp_o})); // R10
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R7
   AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |=> (valid_o || $stable(code_o))); // R7
   AST_COARSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      fine_ramp_o |=> $stable(crs_q)); // R4
   AST_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      lat_q <= LAT_W'(MAX_CYC)); // R9
endmodule

// File: tb/tb_twostep_ramp_seq.sv
module tb_twostep_ramp_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cmp_i = 1'b0;
   logic        coarse_ramp_o, fine_ramp_o, hold_o, valid_o;
   logic [13:0] code_o;

   int tests = 0, fails = 0;
   int tc = 0, tf = 0, cidx = 0, fidx = 0;
   int hold_bad = 0, both_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   twostep_ramp_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .coarse_ramp_o(coarse_ramp_o), .fine_ramp_o(fine_ramp_o),
      .hold_o(hold_o), .code_o(code_o), .valid_o(valid_o)
   );

   // comparator model: step function of ramp step index
   initial begin
      forever begin
         @(negedge clk);
         if (coarse_ramp_o && fine_ramp_o) both_bad++;
         if (coarse_ramp_o) begin
            cmp_i = (cidx >= tc);
            cidx++;
         end else if (fine_ramp_o) begin
            cmp_i = (fidx >= tf);
            fidx++;
            if (!hold_o) hold_bad++;
         end else begin
            cmp_i = 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int expect_code(input int c, input int f);
      int ec, ef, m;
      ec = (c > 127) ? 127 : c;
      ef = (f > 255) ? 255 : f;
      m  = ec * 128 + ef - 64;
      if (m < 0) m = 0;
      if (m > 16383) m = 16383;
      return m;
   endfunction

   task automatic run_conv(input int c, input int f, input int mid);
      int n, exp_code, exp_clen, hb0;
      tc = c; tf = f; cidx = 0; fidx = 0;
      hb0 = hold_bad;
      exp_code = expect_code(c, f);
      exp_clen = (c + 3 > 128) ? 128 : c + 3;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      while (!valid_o && n < 600) begin
         start_i = (mid != 0 && n == mid);
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      check(valid_o == 1'b1 && n <= 500, "R9 latency", n, 500);
      check(int'(code_o) == exp_code, "R3/R5/R6 merged code", int'(code_o), exp_code);
      check(cidx == exp_clen, "R2/R4 coarse ramp length", cidx, exp_clen);
      check(hold_bad == hb0 && fidx > 0, "R4 hold during fine", hold_bad - hb0, 0);
      @(negedge clk);
      check(valid_o == 1'b0, "R7 valid one cycle", int'(valid_o), 0);
      @(negedge clk);
      @(negedge clk);
      check(int'(code_o) == exp_code, "R7 code held", int'(code_o), exp_code);
      if (mid != 0)
         check(coarse_ramp_o == 1'b0 && hold_o == 1'b0, "R8 no second conversion",
               int'(coarse_ramp_o), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!coarse_ramp_o && !fine_ramp_o && !hold_o && !valid_o && code_o == 14'd0,
            "R1 reset state", int'(code_o), 0);

      // R3 R5 R6: sweep every coarse trip point, spread fine trip points
      for (int t = 0; t < 128; t++) run_conv(t, (t * 37 + 5) % 262, 0);

      // R6 boundaries: clamp low, clamp high, offset
      run_conv(0, 0, 0);
      run_conv(0, 63, 0);
      run_conv(0, 100, 0);
      run_conv(1, 0, 0);
      run_conv(300, 300, 0);
      run_conv(127, 192, 0);
      run_conv(126, 255, 0);

      // R8: extra start during coarse and fine phases
      run_conv(5, 200, 20);
      run_conv(50, 10, 200);
      run_conv(300, 300, 300);

      tests++;
      if (both_bad != 0) begin
         fails++;
         $display("FAIL R10 both ramps high actual=%0d expected=0", both_bad);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule